// File: doc/BRIEF.md
# Debug Hart Handshake Region

This block is a memory-mapped slave inside a processor debug module. Harts that run the fixed debug ROM talk to it only by storing to and loading from a few fixed offsets. A hart stores its ID to report that it is halted, and it repeats that store while it polls. It loads its own go byte to learn whether to proceed. It stores to an acknowledge offset when it leaves the poll loop. It stores its ID again when it resumes, and it stores to an exception offset if it faults while in debug mode. The block turns these stores into a per-hart halted vector and a sticky exception flag, and both face the debugger side.

The debugger side asks a halted hart to proceed with a single-cycle go request that carries the hart ID and a target code. The block builds a jump instruction, JAL with rd=x0, from the variable slot at 0x300 to the chosen target. It writes that instruction into the variable slot first. It raises the hart's go byte one cycle later, so a hart never sees the go byte before the jump word is in place. Only one go can be in flight at any time.

Bus requests use a valid/ready channel and read data returns on a valid/ready response channel. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A write takes effect at that edge and produces no response. A read places its data on `rsp_rdata` and raises `rsp_valid` after the accepting edge. While a response is held by `rsp_ready` low, `req_ready` stays low and no new request is taken.

Top module: `dbg_hart_hsk`

## Requirements
- R1: An accepted word write to offset 0x100 whose data is a hart ID below NHARTS sets that hart's bit in `halted_o` after the edge. Data at or above NHARTS is ignored.
- R2: An accepted word write to offset 0x108 whose data is a valid hart ID clears that hart's bit in `halted_o`.
- R3: An accepted write to offset 0x10C sets `exc_o`, which stays set until a `dbg_exc_clr` pulse. If the write and the pulse arrive in the same cycle, the set wins.
- R4: A go request is taken only when all of the following hold: the target code is 0, 1 or 2; the hart is halted; and no go is staged or raised. Any other go request leaves the variable word and all go bytes unchanged.
- R5: The variable word, read at 0x300, is a JAL with rd=x0 and opcode 1101111. Its offset runs from 0x300 to the target: code 0 selects the abstract-command entry (default 0x340), code 1 selects the program buffer (default 0x360), and code 2 selects the resume slot at 0x804. After reset the word jumps to 0x804.
- R6: The go byte of hart h is bit 0 of byte lane h%4 in the word at 0x400 + 4*(h/4), and it reads 0x01 when raised. It rises one cycle after the variable word is updated. A read accepted at the edge after the go request still sees the byte clear and the new word.
- R7: Any accepted write to 0x104 clears the raised go byte, whatever the data.
- R8: At most one go byte is nonzero at any time.
- R9: Reads return zero from the write-only offsets 0x100, 0x104, 0x108 and 0x10C, from unmapped offsets such as the ROM image at 0x800, and from any address with bits [1:0] nonzero. Writes to unmapped offsets change no state.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A pending response keeps `rsp_valid` and `rsp_rdata` stable until it is accepted.
- R11: After reset `halted_o` and `exc_o` are zero and every go byte reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the region |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 32 | Read data |
| dbg_go_valid | input | 1 | Single-cycle go request from the debugger side |
| dbg_go_hart | input | HID_W | Hart addressed by the go request |
| dbg_go_tgt | input | 2 | Target code: 0 abstract, 1 program buffer, 2 resume, 3 reserved |
| dbg_exc_clr | input | 1 | Pulse that clears the exception flag |
| halted_o | output | NHARTS | Per-hart halted flags |
| exc_o | output | 1 | Sticky exception flag |

## Verification
The assertions check the following on every cycle: at most one go byte is raised; the variable word has settled before any go byte rises; the halted, resume and exception stores have their effect; an acknowledge clears the go byte; and a held response stays stable and blocks new requests. Other properties show only in the bench's scenarios. These are the JAL encoding for each target code, a go request being dropped for a hart that is not halted or while another go is in flight, zero reads from write-only and unmapped offsets, and the one-cycle window in which the new word is visible but the go byte is still clear.

// File: rtl/dbg_hsk_pkg.sv
package dbg_hsk_pkg;
  localparam int unsigned OFF_HALT    = 32'h100;
  localparam int unsigned OFF_GOING   = 32'h104;
  localparam int unsigned OFF_RESUME  = 32'h108;
  localparam int unsigned OFF_EXC     = 32'h10C;
  localparam int unsigned OFF_WHERETO = 32'h300;
  localparam int unsigned OFF_FLAGS   = 32'h400;
  localparam int unsigned OFF_ROM     = 32'h800;
  // resume slot is the second word of the fixed image
  localparam int unsigned RESUME_ADDR = OFF_ROM + 32'h4;

  typedef enum logic [1:0] {
    TGT_ABSTRACT = 2'd0,
    TGT_PROGBUF  = 2'd1,
    TGT_RESUME   = 2'd2,
    TGT_RSVD     = 2'd3
  } go_tgt_e;

  typedef enum logic [1:0] {
    RSEL_ZERO    = 2'd0,
    RSEL_WHERETO = 2'd1,
    RSEL_FLAGS   = 2'd2
  } rd_sel_e;

  // JAL x0, off: imm[20|10:1|11|19:12], rd = 0, opcode 1101111
  function automatic logic [31:0] jal_x0(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'b1101111};
  endfunction
endpackage

// File: rtl/dbg_hsk_decode.sv
module dbg_hsk_decode
  import dbg_hsk_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FLAG_WORDS = 1,
  localparam int FI_W      = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1
) (
  input  logic              fire,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_halt,
  output logic              wr_going,
  output logic              wr_resume,
  output logic              wr_exc,
  output logic              rd_acc,
  output rd_sel_e           rd_sel,
  output logic [FI_W-1:0]   flag_idx
);
  localparam int AW_W = ADDR_W - 2;
  localparam logic [AW_W-1:0] W_HALT    = AW_W'(OFF_HALT    >> 2);
  localparam logic [AW_W-1:0] W_GOING   = AW_W'(OFF_GOING   >> 2);
  localparam logic [AW_W-1:0] W_RESUME  = AW_W'(OFF_RESUME  >> 2);
  localparam logic [AW_W-1:0] W_EXC     = AW_W'(OFF_EXC     >> 2);
  localparam logic [AW_W-1:0] W_WHERETO = AW_W'(OFF_WHERETO >> 2);
  localparam logic [AW_W-1:0] W_FLAG0   = AW_W'(OFF_FLAGS   >> 2);
  localparam logic [AW_W-1:0] W_FLAGN   = AW_W'((OFF_FLAGS >> 2) + FLAG_WORDS);

  logic [AW_W-1:0] word;
  logic            aligned;
  logic            wr_fire;
  logic            in_flags;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign wr_fire  = fire && write && aligned;
  assign in_flags = (word >= W_FLAG0) && (word < W_FLAGN);

  assign wr_halt   = wr_fire && (word == W_HALT);
  assign wr_going  = wr_fire && (word == W_GOING);
  assign wr_resume = wr_fire && (word == W_RESUME);
  assign wr_exc    = wr_fire && (word == W_EXC);
  assign rd_acc    = fire && !write;
  assign flag_idx  = FI_W'(word - W_FLAG0);

  always_comb begin
    rd_sel = RSEL_ZERO;
    if (aligned) begin
      if (word == W_WHERETO) rd_sel = RSEL_WHERETO;
      else if (in_flags)     rd_sel = RSEL_FLAGS;
    end
  end
endmodule

// File: rtl/dbg_hsk_hart_state.sv
module dbg_hsk_hart_state #(
  parameter int NHARTS = 4,
  localparam int HID_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_halt,
  input  logic              wr_resume,
  input  logic              wr_exc,
  input  logic              exc_clr,
  input  logic [31:0]       wdata,
  output logic [NHARTS-1:0] halted,
  output logic              exc
);
  logic             id_ok;
  logic [HID_W-1:0] id;

  assign id_ok = (wdata < 32'(NHARTS));
  assign id    = wdata[HID_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= '0;
    end else if (id_ok) begin
      if (wr_halt)        halted[id] <= 1'b1;
      else if (wr_resume) halted[id] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exc <= 1'b0;
    else if (wr_exc)  exc <= 1'b1;
    else if (exc_clr) exc <= 1'b0;
  end
endmodule

// File: rtl/dbg_hsk_go_ctrl.sv
module dbg_hsk_go_ctrl
  import dbg_hsk_pkg::*;
#(
  parameter int NHARTS        = 4,
  parameter int unsigned ABS_ADDR  = 32'h340,
  parameter int unsigned PROG_ADDR = 32'h360,
  localparam int HID_W        = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_valid,
  input  logic [HID_W-1:0]  go_hart,
  input  logic [1:0]        go_tgt,
  input  logic [NHARTS-1:0] halted,
  input  logic              ack,
  output logic [31:0]       whereto,
  output logic [NHARTS-1:0] go_flags,
  output logic              stage_pend
);
  localparam logic [20:0] OFS_ABS  = 21'(ABS_ADDR - OFF_WHERETO);
  localparam logic [20:0] OFS_PROG = 21'(PROG_ADDR - OFF_WHERETO);
  localparam logic [20:0] OFS_RES  = 21'(RESUME_ADDR - OFF_WHERETO);

  logic [HID_W-1:0] stage_hart;
  logic             busy;
  logic             take;
  logic [20:0]      ofs;
  logic [NHARTS-1:0] set_vec;

  assign busy = stage_pend || (|go_flags);
  assign take = go_valid && (go_tgt != TGT_RSVD) &&
                ({{(32-HID_W){1'b0}}, go_hart} < 32'(NHARTS)) &&
                halted[go_hart] && !busy;

  always_comb begin
    unique case (go_tgt_e'(go_tgt))
      TGT_ABSTRACT: ofs = OFS_ABS;
      TGT_PROGBUF:  ofs = OFS_PROG;
      default:      ofs = OFS_RES;
    endcase
  end

  generate
    for (genvar h = 0; h < NHARTS; h++) begin : g_set
      assign set_vec[h] = (stage_hart == HID_W'(h));
    end
  endgenerate

  // stage 1: variable word; stage 2: go byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whereto    <= jal_x0(OFS_RES);
      stage_pend <= 1'b0;
      stage_hart <= '0;
    end else begin
      stage_pend <= take;
      if (take) begin
        whereto    <= jal_x0(ofs);
        stage_hart <= go_hart;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          go_flags <= '0;
    else if (stage_pend) go_flags <= set_vec;
    else if (ack)        go_flags <= '0;
  end
endmodule

// File: rtl/dbg_hsk_rd_port.sv
module dbg_hsk_rd_port
  import dbg_hsk_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int FLAG_WORDS = 1,
  localparam int FI_W      = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  rd_sel_e           rd_sel,
  input  logic [FI_W-1:0]   flag_idx,
  input  logic [31:0]       whereto,
  input  logic [NHARTS-1:0] go_flags,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  logic [FLAG_WORDS*4-1:0] padded;
  logic [31:0]             flag_word;
  logic [31:0]             rd_mux;

  assign padded = (FLAG_WORDS*4)'(go_flags);

  generate
    for (genvar j = 0; j < 4; j++) begin : g_lane
      assign flag_word[8*j +: 8] = {7'd0, padded[{flag_idx, 2'(j)}]};
    end
  endgenerate

  always_comb begin
    unique case (rd_sel)
      RSEL_WHERETO: rd_mux = whereto;
      RSEL_FLAGS:   rd_mux = flag_word;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_hart_hsk.sv
module dbg_hart_hsk
  import dbg_hsk_pkg::*;
#(
  parameter int ADDR_W            = 12,
  parameter int NHARTS            = 4,
  parameter int unsigned ABS_ADDR  = 32'h340,
  parameter int unsigned PROG_ADDR = 32'h360,
  localparam int HID_W            = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  localparam int FLAG_WORDS       = (NHARTS + 3) / 4,
  localparam int FI_W             = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              dbg_go_valid,
  input  logic [HID_W-1:0]  dbg_go_hart,
  input  logic [1:0]        dbg_go_tgt,
  input  logic              dbg_exc_clr,
  output logic [NHARTS-1:0] halted_o,
  output logic              exc_o
);
  logic              fire;
  logic              wr_halt, wr_going, wr_resume, wr_exc, rd_acc;
  rd_sel_e           rd_sel;
  logic [FI_W-1:0]   flag_idx;
  logic [31:0]       whereto;
  logic [NHARTS-1:0] go_flags;
  logic              stage_pend;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  dbg_hsk_decode #(.ADDR_W(ADDR_W), .FLAG_WORDS(FLAG_WORDS)) u_dec (
    .fire(fire), .write(req_write), .addr(req_addr),
    .wr_halt(wr_halt), .wr_going(wr_going), .wr_resume(wr_resume),
    .wr_exc(wr_exc), .rd_acc(rd_acc), .rd_sel(rd_sel), .flag_idx(flag_idx)
  );

  dbg_hsk_hart_state #(.NHARTS(NHARTS)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_halt(wr_halt), .wr_resume(wr_resume),
    .wr_exc(wr_exc), .exc_clr(dbg_exc_clr), .wdata(req_wdata),
    .halted(halted_o), .exc(exc_o)
  );

  dbg_hsk_go_ctrl #(.NHARTS(NHARTS), .ABS_ADDR(ABS_ADDR), .PROG_ADDR(PROG_ADDR)) u_go (
    .clk(clk), .rst_n(rst_n), .go_valid(dbg_go_valid), .go_hart(dbg_go_hart),
    .go_tgt(dbg_go_tgt), .halted(halted_o), .ack(wr_going),
    .whereto(whereto), .go_flags(go_flags), .stage_pend(stage_pend)
  );

  dbg_hsk_rd_port #(.NHARTS(NHARTS), .FLAG_WORDS(FLAG_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .rd_sel(rd_sel),
    .flag_idx(flag_idx), .whereto(whereto), .go_flags(go_flags),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/dbg_hart_hsk_checker.sv
module dbg_hart_hsk_checker #(
  parameter int ADDR_W = 12,
  parameter int NHARTS = 4,
  localparam int HID_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              dbg_exc_clr,
  input logic [NHARTS-1:0] halted_o,
  input logic              exc_o,
  input logic [NHARTS-1:0] go_flags,
  input logic              stage_pend,
  input logic [31:0]       whereto
);
  logic wr_acc, id_ok;
  assign wr_acc = req_valid && req_ready && req_write;
  assign id_ok  = (req_wdata < 32'(NHARTS));

  assert_one_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_flags));

  assert_word_before_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|go_flags) |-> $stable(whereto));

  assert_halt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'(32'h100) && id_ok)
      |=> halted_o[$past(req_wdata[HID_W-1:0])]);

  assert_resume_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'(32'h108) && id_ok)
      |=> !halted_o[$past(req_wdata[HID_W-1:0])]);

  assert_exc_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'(32'h10C)) |=> exc_o);

  assert_exc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc_clr && !(wr_acc && req_addr == ADDR_W'(32'h10C))) |=> !exc_o);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'(32'h104) && !stage_pend) |=> (go_flags == '0));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_ready_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind dbg_hart_hsk dbg_hart_hsk_checker #(.ADDR_W(ADDR_W), .NHARTS(NHARTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .dbg_exc_clr(dbg_exc_clr), .halted_o(halted_o), .exc_o(exc_o),
  .go_flags(go_flags), .stage_pend(stage_pend), .whereto(whereto)
);

// File: tb/dbg_hart_hsk_test.sv
module dbg_hart_hsk_test;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        dbg_go_valid = 1'b0, dbg_exc_clr = 1'b0;
  logic [1:0]  dbg_go_hart = '0, dbg_go_tgt = '0;
  logic [NH-1:0] halted_o;
  logic        exc_o;

  int vectors = 0, misses = 0;
  bit done = 0;

  // reference model
  logic [NH-1:0] m_halted = '0;
  logic          m_exc = 1'b0;
  logic [NH-1:0] m_flags = '0;
  logic [31:0]   m_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_hart_hsk uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dbg_go_valid(dbg_go_valid), .dbg_go_hart(dbg_go_hart), .dbg_go_tgt(dbg_go_tgt),
    .dbg_exc_clr(dbg_exc_clr), .halted_o(halted_o), .exc_o(exc_o)
  );

  function automatic logic [31:0] jal_ref(input int target);
    logic [20:0] o;
    logic [31:0] w;
    o = 21'(target - 32'h300);
    w = 32'h0000006F;
    w[31] = o[20];
    w[30:21] = o[10:1];
    w[20] = o[11];
    w[19:12] = o[19:12];
    return w;
  endfunction

  function automatic logic [31:0] tgt_word(input logic [1:0] t);
    case (t)
      2'd0: return jal_ref(32'h340);
      2'd1: return jal_ref(32'h360);
      default: return jal_ref(32'h804);
    endcase
  endfunction

  function automatic logic [31:0] flag_ref(input logic [NH-1:0] f);
    logic [31:0] w = '0;
    for (int j = 0; j < NH; j++) w[8*j] = f[j];
    return w;
  endfunction

  function automatic logic [31:0] rd_ref(input logic [11:0] a);
    if (a == 12'h300) return m_word;
    if (a == 12'h400) return flag_ref(m_flags);
    return 32'h0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic rd_check(input logic [11:0] a, input string req);
    logic [31:0] d;
    bus_rd(a, d);
    check(d, rd_ref(a), req);
  endtask

  task automatic go_cmd(input logic [1:0] h, input logic [1:0] t);
    bit ok;
    ok = (t != 2'd3) && m_halted[h] && (m_flags == '0);
    @(negedge clk);
    dbg_go_valid = 1'b1; dbg_go_hart = h; dbg_go_tgt = t;
    @(negedge clk);
    dbg_go_valid = 1'b0;
    @(negedge clk);
    if (ok) begin
      m_word = tgt_word(t);
      m_flags[h] = 1'b1;
    end
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h100 && d < NH) m_halted[d[1:0]] = 1'b1;
    if (a == 12'h108 && d < NH) m_halted[d[1:0]] = 1'b0;
    if (a == 12'h10C) m_exc = 1'b1;
    if (a == 12'h104) m_flags = '0;
  endtask

  task automatic status_check(input string req);
    check(32'(halted_o), 32'(m_halted), req);
    check(32'(exc_o), 32'(m_exc), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, hold;
    void'($urandom(32'd20251));
    m_word = jal_ref(32'h804);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check(32'(halted_o), 32'h0, "R11");
    check(32'(exc_o), 32'h0, "R11");
    rd_check(12'h400, "R11");
    rd_check(12'h300, "R5");

    // R1 halt store, out-of-range id ignored
    bus_wr(12'h100, 32'd2); model_wr(12'h100, 32'd2);
    status_check("R1");
    bus_wr(12'h100, 32'd9); status_check("R1");

    // R4 go for a non-halted hart ignored
    go_cmd(2'd1, 2'd0);
    rd_check(12'h400, "R4"); rd_check(12'h300, "R4");
    // R4 reserved target ignored
    go_cmd(2'd2, 2'd3);
    rd_check(12'h400, "R4");

    // R6 ordering: read accepted at edge after the request
    @(negedge clk);
    dbg_go_valid = 1'b1; dbg_go_hart = 2'd2; dbg_go_tgt = 2'd1;
    @(negedge clk);
    dbg_go_valid = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h400;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata, 32'h0, "R6");
    m_word = jal_ref(32'h360); m_flags[2] = 1'b1;
    rd_check(12'h300, "R5");
    rd_check(12'h400, "R6");

    // R4 second go while one raised is ignored
    bus_wr(12'h100, 32'd0); model_wr(12'h100, 32'd0);
    go_cmd(2'd0, 2'd0);
    rd_check(12'h400, "R8"); rd_check(12'h300, "R4");

    // R7 ack with arbitrary data
    bus_wr(12'h104, 32'hFFFF_0000); model_wr(12'h104, 32'hFFFF_0000);
    rd_check(12'h400, "R7");

    // R5 abstract and resume targets
    go_cmd(2'd0, 2'd0); rd_check(12'h300, "R5"); rd_check(12'h400, "R6");
    bus_wr(12'h104, 32'h0); model_wr(12'h104, 32'h0);
    go_cmd(2'd2, 2'd2); rd_check(12'h300, "R5");
    bus_wr(12'h104, 32'h0); model_wr(12'h104, 32'h0);

    // R2 resume store
    bus_wr(12'h108, 32'd2); model_wr(12'h108, 32'd2); status_check("R2");

    // R3 exception and clear, and set winning over clear
    bus_wr(12'h10C, 32'h0); model_wr(12'h10C, 32'h0); status_check("R3");
    @(negedge clk); dbg_exc_clr = 1'b1; @(negedge clk); dbg_exc_clr = 1'b0;
    m_exc = 1'b0; status_check("R3");
    @(negedge clk);
    dbg_exc_clr = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h10C;
    @(negedge clk);
    dbg_exc_clr = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    m_exc = 1'b1; status_check("R3");

    // R9 write-only, unmapped, misaligned
    rd_check(12'h100, "R9"); rd_check(12'h10C, "R9"); rd_check(12'h800, "R9");
    bus_rd(12'h302, d); check(d, 32'h0, "R9");
    bus_wr(12'h500, 32'd1); bus_wr(12'h102, 32'd1); status_check("R9");

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h300;
    @(negedge clk);
    req_valid = 1'b0; hold = rsp_rdata;
    check(32'(req_ready), 32'h0, "R10");
    repeat (2) @(negedge clk);
    check(32'(rsp_valid), 32'h1, "R10");
    check(rsp_rdata, hold, "R10");
    check(hold, m_word, "R10");
    rsp_ready = 1'b1;

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      logic [31:0] id = $urandom_range(0, 5);
      case (op)
        0: begin bus_wr(12'h100, id); model_wr(12'h100, id); status_check("R1"); end
        1: begin bus_wr(12'h108, id); model_wr(12'h108, id); status_check("R2"); end
        2: begin bus_wr(12'h10C, id); model_wr(12'h10C, id); status_check("R3"); end
        3: begin
             @(negedge clk); dbg_exc_clr = 1'b1; @(negedge clk); dbg_exc_clr = 1'b0;
             m_exc = 1'b0; status_check("R3");
           end
        4: begin bus_wr(12'h104, $urandom); model_wr(12'h104, 32'h0); rd_check(12'h400, "R7"); end
        5: begin
             go_cmd(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
             rd_check(12'h400, "R4"); rd_check(12'h300, "R5");
           end
        6: begin
             logic [11:0] a;
             case ($urandom_range(0, 3))
               0: a = 12'h300; 1: a = 12'h400; 2: a = 12'h104; default: a = 12'h804;
             endcase
             rd_check(a, "R9");
           end
        default: begin bus_wr(12'(12'h600 + 4*$urandom_range(0, 100)), $urandom); status_check("R9"); end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule